// File: doc/BRIEF.md
# DPLL Frequency Limit Alarm

This block watches the frequency offset of a DPLL output, measured against the master clock, and raises two alarms. Each alarm has its own programmable limit. The offset arrives as a signed fixed-point sample whose LSB is 0.0001 ppm, together with a one-cycle valid pulse. The block takes the magnitude of each sample and compares it with both limits.

The limits are given as register codes with fixed ppm weights:

- The soft limit code is 7 bits wide and weighs 0.724 ppm per step.
- The hard limit code is 16 bits wide and weighs 0.0014 ppm per step.

Inside the block, both codes are scaled into the offset's own 0.0001 ppm unit, so a single comparison rule applies to both alarms. The soft alarm is a status output only. The hard alarm is passed on as a lock-breaking event, but only while a separate enable is set. The block does not measure the frequency offset itself.

Top module: `freq_limit_alarm`

## Requirements
- R1: After reset, `soft_alarm`, `hard_alarm` and `hard_unlock_evt` are all 0.
- R2: The soft limit in 0.0001 ppm units equals `soft_code` × 7240. `soft_alarm` becomes 1 when a valid sample's magnitude is strictly greater than this limit.
- R3: An alarm is 0 after a valid sample whose magnitude is less than or equal to its limit. Equality does not raise an alarm, and a magnitude back within the limit clears an alarm that was set.
- R4: The hard limit in 0.0001 ppm units equals `hard_code` × 14. `hard_alarm` becomes 1 when a valid sample's magnitude is strictly greater than this limit.
- R5: A negative offset is judged by its magnitude, so −N produces the same alarms as +N.
- R6: The most negative input, 0x80000000, saturates to a magnitude of 2^31−1 and does not wrap. Both alarms are set even when both codes are at their maximum.
- R7: Both alarms keep their value in every cycle where `ofs_valid` is 0, whatever `ofs_value` and the codes do.
- R8: `hard_unlock_evt` is 1 exactly when `hard_alarm` is 1 and `hard_lock_en` is 1. The soft alarm never drives it.
- R9: The alarms update on the clock edge that samples `ofs_valid`=1. Before that edge they still show the previous result, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ofs_valid | input | 1 | One-cycle strobe: a new offset sample is present |
| ofs_value | input | 32 | Signed frequency offset, LSB = 0.0001 ppm |
| soft_code | input | 7 | Soft limit code, 0.724 ppm per step |
| hard_code | input | 16 | Hard limit code, 0.0014 ppm per step |
| hard_lock_en | input | 1 | Lets the hard alarm break lock |
| soft_alarm | output | 1 | Soft limit exceeded (status only) |
| hard_alarm | output | 1 | Hard limit exceeded |
| hard_unlock_evt | output | 1 | Hard alarm, gated by `hard_lock_en` |

## Verification
The bench probes each limit at exactly the limit and at one LSB above it. A design that uses a greater-or-equal comparison alarms at the limit, and a wrong scale factor shifts where the boundary falls. Negative samples and the most negative code are applied as well: a two's-complement negation without saturation wraps 0x80000000 to a huge negative or zero magnitude, and the alarm then fails to assert. Further tests change the offset while no valid pulse is present, and toggle the enable while the hard or soft alarm alone is set. These catch a design that compares every cycle, or that lets the soft alarm reach the unlock output.

// File: rtl/freq_lim_pkg.sv
package freq_lim_pkg;
   // Weights that bring each limit code into the 0.0001 ppm offset unit
   localparam int unsigned SOFT_WEIGHT_DEF = 7240;
   localparam int unsigned HARD_WEIGHT_DEF = 14;

   typedef enum logic {
      SCALE_MULT     = 1'b0,
      SCALE_SHIFTADD = 1'b1
   } scale_mode_e;
endpackage

// File: rtl/flim_magnitude.sv
module flim_magnitude #(
   parameter int unsigned OFS_W = 32,
   localparam int unsigned MAG_W = OFS_W - 1
) (
   input  logic [OFS_W-1:0] ofs_i,
   output logic [MAG_W-1:0] mag_o
);
   localparam logic [OFS_W-1:0] MOST_NEG = {1'b1, {(OFS_W-1){1'b0}}};

   logic [OFS_W-1:0] negated;

   generate
      if (OFS_W < 2) begin : g_bad_width
         $error("flim_magnitude: OFS_W must be at least 2");
      end
   endgenerate

   always_comb begin
      negated = ~ofs_i + 1'b1;
      if (!ofs_i[OFS_W-1]) begin
         mag_o = ofs_i[MAG_W-1:0];
      end else if (ofs_i == MOST_NEG) begin
         mag_o = '1;                       // saturate instead of wrapping
      end else begin
         mag_o = negated[MAG_W-1:0];
      end
   end
endmodule

// File: rtl/flim_scaler.sv
module flim_scaler
   import freq_lim_pkg::*;
#(
   parameter int unsigned CODE_W = 7,
   parameter int unsigned WEIGHT = SOFT_WEIGHT_DEF,
   parameter int unsigned LIM_W  = 31,
   parameter scale_mode_e MODE   = SCALE_MULT
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [LIM_W-1:0]  lim_o
);
   localparam int unsigned WEIGHT_BITS = $clog2(WEIGHT + 1);

   generate
      if (CODE_W + WEIGHT_BITS > LIM_W) begin : g_bad_range
         $error("flim_scaler: scaled limit does not fit LIM_W");
      end
      if (WEIGHT == 0) begin : g_bad_weight
         $error("flim_scaler: WEIGHT must be nonzero");
      end

      if (MODE == SCALE_MULT) begin : g_mult
         assign lim_o = LIM_W'(code_i) * LIM_W'(WEIGHT);
      end else begin : g_shiftadd
         logic [LIM_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int b = 0; b < WEIGHT_BITS; b++) begin
               if (WEIGHT[b]) acc = acc + (LIM_W'(code_i) << b);
            end
         end
         assign lim_o = acc;
      end
   endgenerate
endmodule

// File: rtl/flim_compare.sv
module flim_compare #(
   parameter int unsigned MAG_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic [MAG_W-1:0] mag_i,
   input  logic [MAG_W-1:0] lim_i,
   output logic             alarm_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_o <= 1'b0;
      end else if (upd_i) begin
         alarm_o <= (mag_i > lim_i);
      end
   end
endmodule

// File: rtl/freq_limit_alarm.sv
module freq_limit_alarm
   import freq_lim_pkg::*;
#(
   parameter int unsigned OFS_W       = 32,
   parameter int unsigned SOFT_CODE_W = 7,
   parameter int unsigned HARD_CODE_W = 16,
   parameter int unsigned SOFT_WEIGHT = SOFT_WEIGHT_DEF,
   parameter int unsigned HARD_WEIGHT = HARD_WEIGHT_DEF,
   parameter scale_mode_e SOFT_MODE   = SCALE_SHIFTADD,
   parameter scale_mode_e HARD_MODE   = SCALE_MULT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ofs_valid,
   input  logic [OFS_W-1:0]       ofs_value,
   input  logic [SOFT_CODE_W-1:0] soft_code,
   input  logic [HARD_CODE_W-1:0] hard_code,
   input  logic                   hard_lock_en,
   output logic                   soft_alarm,
   output logic                   hard_alarm,
   output logic                   hard_unlock_evt
);
   localparam int unsigned MAG_W = OFS_W - 1;
   localparam logic [OFS_W-1:0] MOST_NEG = {1'b1, {(OFS_W-1){1'b0}}};

   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] soft_lim;
   logic [MAG_W-1:0] hard_lim;

   flim_magnitude #(.OFS_W(OFS_W)) u_mag (
      .ofs_i (ofs_value),
      .mag_o (mag)
   );

   flim_scaler #(
      .CODE_W (SOFT_CODE_W), .WEIGHT (SOFT_WEIGHT), .LIM_W (MAG_W), .MODE (SOFT_MODE)
   ) u_soft_scale (
      .code_i (soft_code),
      .lim_o  (soft_lim)
   );

   flim_scaler #(
      .CODE_W (HARD_CODE_W), .WEIGHT (HARD_WEIGHT), .LIM_W (MAG_W), .MODE (HARD_MODE)
   ) u_hard_scale (
      .code_i (hard_code),
      .lim_o  (hard_lim)
   );

   flim_compare #(.MAG_W(MAG_W)) u_soft_cmp (
      .clk (clk), .rst_n (rst_n), .upd_i (ofs_valid),
      .mag_i (mag), .lim_i (soft_lim), .alarm_o (soft_alarm)
   );

   flim_compare #(.MAG_W(MAG_W)) u_hard_cmp (
      .clk (clk), .rst_n (rst_n), .upd_i (ofs_valid),
      .mag_i (mag), .lim_i (hard_lim), .alarm_o (hard_alarm)
   );

   // Only the hard alarm may break lock, and only when enabled
   assign hard_unlock_evt = hard_alarm & hard_lock_en;

   AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_valid && (mag > soft_lim) |=> soft_alarm);                      // R2
   AST_WITHIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_valid && (mag <= hard_lim) |=> !hard_alarm);                    // R3
   AST_HARD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_valid && (mag > hard_lim) |=> hard_alarm);                      // R4
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_valid && (ofs_value == MOST_NEG) |=> soft_alarm && hard_alarm); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ofs_valid |=> $stable(soft_alarm) && $stable(hard_alarm));         // R7
   AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hard_unlock_evt) |-> hard_alarm && hard_lock_en);             // R8
endmodule

// File: tb/freq_limit_alarm_tb.sv
module freq_limit_alarm_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ofs_valid = 1'b0;
   logic [31:0] ofs_value = '0;
   logic [6:0]  soft_code = '0;
   logic [15:0] hard_code = '0;
   logic        hard_lock_en = 1'b0;
   logic        soft_alarm, hard_alarm, hard_unlock_evt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   freq_limit_alarm u_dut (
      .clk (clk), .rst_n (rst_n), .ofs_valid (ofs_valid), .ofs_value (ofs_value),
      .soft_code (soft_code), .hard_code (hard_code), .hard_lock_en (hard_lock_en),
      .soft_alarm (soft_alarm), .hard_alarm (hard_alarm), .hard_unlock_evt (hard_unlock_evt)
   );

   task automatic check(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic longint mag_of(logic [31:0] v);
      longint s = longint'($signed(v));
      longint m = (s < 0) ? -s : s;
      if (m > 64'sd2147483647) m = 64'sd2147483647;
      return m;
   endfunction

   // Apply one sample with a valid pulse, then check both alarms
   task automatic apply_check(string req, logic [31:0] v);
      longint m;
      @(negedge clk);
      ofs_value = v;
      ofs_valid = 1'b1;
      @(negedge clk);
      ofs_valid = 1'b0;
      m = mag_of(v);
      check(req, soft_alarm, m > longint'(soft_code) * 7240);
      check(req, hard_alarm, m > longint'(hard_code) * 14);
      check(req, hard_unlock_evt, (m > longint'(hard_code) * 14) && hard_lock_en);
   endtask

   task automatic t_reset();
      check("R1", soft_alarm, 1'b0);
      check("R1", hard_alarm, 1'b0);
      check("R1", hard_unlock_evt, 1'b0);
   endtask

   task automatic t_soft_boundary();
      soft_code = 7'd10; hard_code = 16'hFFFF;     // soft limit 72400
      apply_check("R3", 32'd72400);
      apply_check("R2", 32'd72401);
      apply_check("R3", 32'd72400);                // clears when back within
   endtask

   task automatic t_hard_boundary();
      soft_code = 7'd127; hard_code = 16'd1000;   // hard limit 14000
      apply_check("R3", 32'd14000);
      apply_check("R4", 32'd14001);
      apply_check("R3", 32'd100);
   endtask

   task automatic t_negative();
      soft_code = 7'd10; hard_code = 16'd1000;
      apply_check("R5", -32'sd14001);
      apply_check("R5", -32'sd72401);
      apply_check("R5", -32'sd14000);
   endtask

   task automatic t_saturate();
      soft_code = 7'd127; hard_code = 16'hFFFF;
      apply_check("R6", 32'h8000_0000);
      check("R6", soft_alarm, 1'b1);
      check("R6", hard_alarm, 1'b1);
      apply_check("R6", 32'h8000_0001);
   endtask

   task automatic t_hold();
      soft_code = 7'd1; hard_code = 16'd1;
      apply_check("R7", 32'd100000);              // both alarms set
      @(negedge clk);
      ofs_value = 32'd0; soft_code = 7'd127; hard_code = 16'hFFFF;
      repeat (3) @(negedge clk);
      check("R7", soft_alarm, 1'b1);
      check("R7", hard_alarm, 1'b1);
      apply_check("R7", 32'd0);                    // valid clears both
   endtask

   task automatic t_enable();
      soft_code = 7'd0; hard_code = 16'd1000;
      hard_lock_en = 1'b0;
      apply_check("R8", 32'd20000);
      check("R8", hard_unlock_evt, 1'b0);
      @(negedge clk); hard_lock_en = 1'b1; #1;
      check("R8", hard_unlock_evt, 1'b1);
      soft_code = 7'd0; hard_code = 16'hFFFF;     // soft only
      apply_check("R8", 32'd20000);
      check("R8", hard_unlock_evt, 1'b0);
      hard_lock_en = 1'b0;
   endtask

   task automatic t_latency();
      soft_code = 7'd0; hard_code = 16'd0;
      apply_check("R9", 32'd0);
      @(negedge clk);
      ofs_value = 32'd5; ofs_valid = 1'b1; #1;
      check("R9", soft_alarm, 1'b0);              // not yet updated
      @(negedge clk);
      ofs_valid = 1'b0;
      check("R9", soft_alarm, 1'b1);
      check("R9", hard_alarm, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_soft_boundary();
      t_hard_boundary();
      t_negative();
      t_saturate();
      t_hold();
      t_enable();
      t_latency();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule